// File: doc/BRIEF.md
# Stochastic Rounding Quantizer

This block turns signed fixed-point feature values into short integer level codes for low-precision training data. The level grid starts at a lower bound supplied with each value and has a spacing of 2^SHIFT input units. It ends at the highest code a CODE_W-bit field can hold. A value between two grid points is rounded to the upper point with a probability equal to its fractional distance from the lower point. The rounded result is therefore unbiased in expectation.

Each value gets two rounding decisions from two independent pseudo-random streams. Both codes are packed into one output word, so later stages receive two uncorrelated copies of the same feature. The streams advance once for every accepted value and never rewind. A later pass over the same data therefore draws new samples and does not repeat earlier rounding decisions. The block accepts one value per clock and returns its codes one cycle later.

Top module: `sr_quantizer`

## Requirements
- R1: While reset is held and in the first cycle after release, `out_valid` is 0 and `out_codes` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1. Each accepted value produces exactly one result, in input order.
- R3: Let the offset be d = in_value - lower. When 0 <= d < (2^CODE_W - 1)·2^SHIFT and d is a multiple of 2^SHIFT, both codes equal d / 2^SHIFT.
- R4: When in_value < lower, both codes are 0.
- R5: When d >= (2^CODE_W - 1)·2^SHIFT, both codes are 2^CODE_W - 1.
- R6: Inside the range, each code is floor(d / 2^SHIFT) plus one round-up bit. The bit is 1 exactly when that lane's 16-bit random sample r, read as unsigned, is below (d mod 2^SHIFT)·2^(16-SHIFT).
- R7: Lane A draws from a right-shifting Galois LFSR with XOR mask 0xB400 and seed 0xACE1. Lane B draws from one with mask 0xD008 and seed 0x1D2B. The sample used for a value is the register state before the step. A step shifts right by one and XORs in the mask when the bit shifted out was 1. Both registers step once per accepted value and hold otherwise.
- R8: The lane A code sits in `out_codes[CODE_W-1:0]` and the lane B code sits in `out_codes[2*CODE_W-1:CODE_W]`.
- R9: In a cycle after one with `in_valid` low, `out_codes` keeps its previous value.
- R10: When one mid-interval value is fed many times in a row, both lanes round up in roughly half of the passes, and the two lanes often disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A value is presented this cycle |
| in_value | input | IN_W | Signed fixed-point feature value |
| lower | input | IN_W | Signed lower bound of the level grid |
| out_valid | output | 1 | Codes for the previous value are present |
| out_codes | output | 2*CODE_W | Lane B code (upper field) and lane A code (lower field) |

## Verification
The bench uses a 16-bit input, 4-bit codes and a grid spacing of 16 units (SHIFT = 4). The full 16-level span and both clamps then lie a few hundred units apart, so directed values can reach every boundary. Each fraction step of the 4-bit fraction maps onto the random comparison with a scale factor of 4096. The bench predicts both random streams from the stated masks and seeds, so every rounding decision is known exactly. A long run on one half-way value then shows the spread of round-up decisions and how independent the two lanes are.

// File: rtl/sr_quantizer.sv
module sr_quantizer #(
  parameter int IN_W = 16,
  parameter int CODE_W = 4,
  parameter int SHIFT = 4,
  parameter logic [15:0] SEED_A = 16'hACE1,
  parameter logic [15:0] SEED_B = 16'h1D2B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_value,
  input  logic signed [IN_W-1:0]  lower,
  output logic                    out_valid,
  output logic [2*CODE_W-1:0]     out_codes
);
  localparam int DW = IN_W + 2;
  localparam int RND_W = 16;
  localparam int MAXC = (1 << CODE_W) - 1;
  localparam logic signed [DW-1:0] SPAN = DW'(MAXC << SHIFT);
  localparam logic [RND_W-1:0] MASK_A = 16'hB400;
  localparam logic [RND_W-1:0] MASK_B = 16'hD008;

  function automatic logic [RND_W-1:0] lfsr_next(logic [RND_W-1:0] s, logic [RND_W-1:0] m);
    return s[0] ? ((s >> 1) ^ m) : (s >> 1);
  endfunction

  logic signed [DW-1:0] diff;
  logic                 below, above;
  logic [CODE_W-1:0]    base;
  logic [RND_W-1:0]     frac_s;
  logic [RND_W-1:0]     lfsr_a, lfsr_b;
  logic [CODE_W-1:0]    code_a, code_b;

  assign diff   = DW'(in_value) - DW'(lower);
  assign below  = diff < 0;
  assign above  = diff >= SPAN;
  assign base   = CODE_W'(diff >>> SHIFT);
  assign frac_s = RND_W'(diff[SHIFT-1:0]) << (RND_W - SHIFT);

  assign code_a = below ? '0 : above ? CODE_W'(MAXC) : base + CODE_W'(lfsr_a < frac_s);
  assign code_b = below ? '0 : above ? CODE_W'(MAXC) : base + CODE_W'(lfsr_b < frac_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_codes <= '0;
      lfsr_a    <= SEED_A;
      lfsr_b    <= SEED_B;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_codes <= {code_b, code_a};
        lfsr_a    <= lfsr_next(lfsr_a, MASK_A);
        lfsr_b    <= lfsr_next(lfsr_b, MASK_B);
      end
    end
  end
endmodule

// File: rtl/sr_quantizer_chk.sv
module sr_quantizer_chk #(
  parameter int IN_W = 16,
  parameter int CODE_W = 4,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] in_value,
  input logic signed [IN_W-1:0] lower,
  input logic                   out_valid,
  input logic [2*CODE_W-1:0]    out_codes,
  input logic [15:0]            lfsr_a,
  input logic [15:0]            lfsr_b
);
  localparam int DW = IN_W + 2;
  localparam int MAXC = (1 << CODE_W) - 1;
  localparam logic signed [DW-1:0] SPAN = DW'(MAXC << SHIFT);

  logic signed [DW-1:0] d;
  logic                 inr;
  logic [CODE_W-1:0]    fl;
  logic [CODE_W-1:0]    ca, cb;

  assign d   = DW'(in_value) - DW'(lower);
  assign inr = (d >= 0) && (d < SPAN);
  assign fl  = CODE_W'(d >>> SHIFT);
  assign ca  = out_codes[CODE_W-1:0];
  assign cb  = out_codes[2*CODE_W-1:CODE_W];

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_exact_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inr && d[SHIFT-1:0] == '0) |=> (ca == $past(fl) && cb == $past(fl)));
  assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && d < 0) |=> out_codes == '0);
  assert_clamp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && d >= SPAN) |=> (ca == CODE_W'(MAXC) && cb == CODE_W'(MAXC)));
  assert_round_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inr) |=> ((ca == $past(fl) || ca == $past(fl) + CODE_W'(1)) &&
                           (cb == $past(fl) || cb == $past(fl) + CODE_W'(1))));
  assert_rng_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr_a != 16'h0) && (lfsr_b != 16'h0));
  assert_rng_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(lfsr_a) && $stable(lfsr_b)));
  assert_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_codes));
endmodule

bind sr_quantizer sr_quantizer_chk #(.IN_W(IN_W), .CODE_W(CODE_W), .SHIFT(SHIFT)) u_chk (.*);

// File: tb/test_sr_quantizer.sv
`timescale 1ns/1ps
module test_sr_quantizer;
  localparam int IN_W = 16;
  localparam int CODE_W = 4;
  localparam int SHIFT = 4;
  localparam int MAXC = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_value = '0;
  logic signed [IN_W-1:0] lower = '0;
  logic out_valid;
  logic [2*CODE_W-1:0] out_codes;

  always #10 clk = ~clk;

  sr_quantizer #(.IN_W(IN_W), .CODE_W(CODE_W), .SHIFT(SHIFT)) i_sr_quantizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .lower(lower), .out_valid(out_valid), .out_codes(out_codes));

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  logic [2*CODE_W-1:0] exp_q[$];
  string tag_q[$];
  logic [15:0] ma = 16'hACE1;
  logic [15:0] mb = 16'h1D2B;
  logic [2*CODE_W-1:0] last_codes = '0;
  int st_n = 0, st_up_a = 0, st_up_b = 0, st_dis = 0;

  function automatic logic [15:0] galois(logic [15:0] s, logic [15:0] m);
    return s[0] ? ((s >> 1) ^ m) : (s >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] model(int v, int l, logic [15:0] r);
    int d, fl, fr;
    d = v - l;
    if (d < 0) return '0;
    if (d >= MAXC * (1 << SHIFT)) return CODE_W'(MAXC);
    fl = d / (1 << SHIFT);
    fr = d % (1 << SHIFT);
    return CODE_W'(fl + ((int'(r) < fr * (1 << (16 - SHIFT))) ? 1 : 0));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(int v, int l, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_value = IN_W'(v);
    lower = IN_W'(l);
    exp_q.push_back({model(v, l, mb), model(v, l, ma)});
    tag_q.push_back(tag);
    ma = galois(ma, 16'hB400);
    mb = galois(mb, 16'hD008);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          logic [2*CODE_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_codes == e, t, int'(out_codes), int'(e));
          if (t == "R10") begin
            st_n++;
            if (out_codes[CODE_W-1:0] == CODE_W'(6)) st_up_a++;
            if (out_codes[2*CODE_W-1:CODE_W] == CODE_W'(6)) st_up_b++;
            if (out_codes[CODE_W-1:0] != out_codes[2*CODE_W-1:CODE_W]) st_dis++;
          end
        end
      end else begin
        check(out_codes == last_codes, "R9 hold", int'(out_codes), int'(last_codes));
      end
      last_codes = out_codes;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_codes == '0, "R1 out_codes", int'(out_codes), 0);
    running = 1'b1;

    l = -100;
    send(l + 7*16 + 8, l, "R8");      // lane A holds 7, lane B rounds to 8
    send(l + 3*16, l, "R3");
    send(l, l, "R3");
    send(l - 5, l, "R4");
    send(-32768, l, "R4");
    send(l + 15*16, l, "R5");
    send(l + 15*16 + 1, l, "R5");
    send(32767, l, "R5");
    send(l + 14*16 + 15, l, "R6");
    send(l + 1, l, "R6");
    idle(3);

    for (int i = 0; i < 20; i++) begin
      send(l + 4*16 + i % 16, l, "R7");
      idle(i % 3);
    end
    idle(2);

    for (int i = 0; i < 300; i++) begin
      int lb;
      lb = int'($urandom_range(400, 0)) - 200;
      send(lb + int'($urandom_range(400, 0)) - 80, lb, "R6");
    end
    idle(2);

    for (int i = 0; i < 2000; i++) send(5*16 + 8, 0, "R10");
    idle(3);

    check(exp_q.size() == 0, "R2 results outstanding", exp_q.size(), 0);
    check(st_n == 2000, "R10 sample count", st_n, 2000);
    check(st_up_a >= 800 && st_up_a <= 1200, "R10 lane A up rate", st_up_a, 1000);
    check(st_up_b >= 800 && st_up_b <= 1200, "R10 lane B up rate", st_up_b, 1000);
    check(st_dis >= 400, "R10 lane disagreement", st_dis, 1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule